// File: doc/BRIEF.md
# Voltage Handshake Sequencer

This block sits in a power controller and runs the target-voltage handshake with a device on a PMBus link. It does not drive the bus. Instead it issues abstract transaction requests to a separate transaction engine and consumes what the engine returns. The request kinds are:

- an alert response address read;
- a status byte read;
- a clear-faults send;
- an output voltage command read.

When the device reports a clean status, the block fetches the device's voltage word and stores it as the new target. A regulator setpoint register then walks toward that target in bounded, spaced steps.

Two entry paths exist, and a mode input picks one:

- **Alert mode.** An asserted alert line starts the handshake, beginning with the alert response read.
- **Polling mode.** The rising edge of the device's configuration-ready line starts the handshake. The status read is retried at a fixed interval for as long as the device refuses it.

A nonzero status is cleared, re-read for confirmation, and handed off through a one-cycle fault output. Any other refused transaction drops the handshake and raises an error flag.

Top module: `vrail_handshake`

## Requirements
- R1: After reset, `setpoint` and `vout_target` equal `SETPT_RST`, and `txn_req`, `fault_valid` and `err_flag` are 0.
- R2: In alert mode (`use_alert`=1), a high `alert_in` while idle starts a request sequence, where `txn_op` encodes 0 = alert response read, 1 = status read, 2 = clear faults, 3 = voltage read. When the status byte (`txn_rdata[7:0]`) is 00h, the ops issued are 0, 1, 2, 3 in that order.
- R3: When the first status byte is nonzero, the ops issued are 0, 1, 2, 1 (in alert mode). After the confirming status read, `fault_valid` pulses for exactly one cycle with `fault_code` equal to the first status byte, and `vout_target` is unchanged.
- R4: In polling mode (`use_alert`=0), a rising edge of `dev_ready` starts the sequence at op 1 with no alert response read. A refused first status read is reissued after exactly `POLL_TICKS` cycles with `txn_req` low. A `dev_ready` that stays high does not restart the sequence.
- R5: Any other refused transaction (`txn_err`) drops `txn_req` and sets `err_flag`, and leaves `vout_target` unchanged. `err_flag` clears when the next handshake starts.
- R6: Each change of `setpoint` is at most `MAX_STEP` in size, and successive changes are at least `STEP_TICKS` cycles apart.
- R7: `setpoint` never passes the target. It ends exactly on `vout_target` after ceil(|target - start| / `MAX_STEP`) changes.
- R8: The voltage word is taken as direct format with unity coefficients, so `vout_target` equals the word in millivolts (0384h gives 900).
- R9: `txn_req` stays high with a stable `txn_op` until `txn_done` or `txn_err` arrives.
- R10: The inactive entry input is ignored: `alert_in` in polling mode, and `dev_ready` in alert mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_alert | input | 1 | 1 = alert entry path, 0 = polling entry path |
| alert_in | input | 1 | Device alert, active high |
| dev_ready | input | 1 | Device configuration-ready level (polling start) |
| txn_req | output | 1 | Transaction request to the engine |
| txn_op | output | 2 | Requested transaction kind |
| txn_done | input | 1 | Engine completed the request |
| txn_err | input | 1 | Engine refused or failed the request |
| txn_rdata | input | 16 | Read data returned with `txn_done` |
| setpoint | output | 16 | Regulator setpoint in mV |
| vout_target | output | 16 | Latest target from the device, in mV |
| fault_valid | output | 1 | One-cycle fault handoff strobe |
| fault_code | output | 8 | Status byte that caused the fault |
| err_flag | output | 1 | Handshake aborted on a refused transaction |

## Verification
The bench sweeps the target offset across every value from -25 to +25 mV around the current setpoint. This covers the deltas that are exact multiples of the step, those one above and one below a multiple, and zero. A ramp that rounds the last step wrongly would overshoot, stall short of the target, or take one step too many or too few. A range of nonzero status bytes, including 80h and FFh, checks that the confirmation read happens and that the first byte, not the confirming one, is handed off; a design that skipped the re-read or latched the wrong byte shows up in the op log or `fault_code`. Polling with two refusals measures the idle gap before each retry, which catches an off-by-one in the poll counter. Refusals on the clear and voltage reads must abort rather than retry, and the mode tests check that the unused start input cannot launch a handshake.

// File: rtl/vrail_handshake.sv
module vrail_handshake #(
  parameter int MAX_STEP   = 10,
  parameter int STEP_TICKS = 2500000,
  parameter int POLL_TICKS = 50000000,
  parameter logic [15:0] SETPT_RST = 16'd800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        use_alert,
  input  logic        alert_in,
  input  logic        dev_ready,
  output logic        txn_req,
  output logic [1:0]  txn_op,
  input  logic        txn_done,
  input  logic        txn_err,
  input  logic [15:0] txn_rdata,
  output logic [15:0] setpoint,
  output logic [15:0] vout_target,
  output logic        fault_valid,
  output logic [7:0]  fault_code,
  output logic        err_flag
);
  localparam int CW = $clog2(STEP_TICKS + 1);
  localparam int PW = $clog2(POLL_TICKS + 1);
  localparam logic [15:0] MAXS = 16'(MAX_STEP);

  typedef enum logic [2:0] {S_IDLE, S_ARA, S_STAT, S_CLR, S_VOUT, S_CONF, S_WAIT} st_t;
  st_t st;
  logic          rdy_q;
  logic [7:0]    stat_q;
  logic [PW-1:0] pcnt;
  logic [CW-1:0] scnt;
  logic [15:0]   mag, stepv;
  logic          up, step_now;

  wire rdy_rise = dev_ready & ~rdy_q;

  assign txn_req = (st == S_ARA) | (st == S_STAT) | (st == S_CLR) |
                   (st == S_VOUT) | (st == S_CONF);

  always_comb begin
    case (st)
      S_ARA:  txn_op = 2'd0;
      S_CLR:  txn_op = 2'd2;
      S_VOUT: txn_op = 2'd3;
      default: txn_op = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rdy_q       <= 1'b0;
      stat_q      <= '0;
      pcnt        <= '0;
      vout_target <= SETPT_RST;
      fault_valid <= 1'b0;
      fault_code  <= '0;
      err_flag    <= 1'b0;
    end else begin
      rdy_q       <= dev_ready;
      fault_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (use_alert && alert_in) begin
            st <= S_ARA;
            err_flag <= 1'b0;
          end else if (!use_alert && rdy_rise) begin
            st <= S_STAT;
            err_flag <= 1'b0;
          end
        end
        S_ARA: begin
          if (txn_err) begin
            st <= S_IDLE;
            err_flag <= 1'b1;
          end else if (txn_done) st <= S_STAT;
        end
        S_STAT: begin
          if (txn_err) begin
            if (!use_alert) begin
              st <= S_WAIT;
              pcnt <= '0;
            end else begin
              st <= S_IDLE;
              err_flag <= 1'b1;
            end
          end else if (txn_done) begin
            stat_q <= txn_rdata[7:0];
            st <= S_CLR;
          end
        end
        S_CLR: begin
          if (txn_err) begin
            st <= S_IDLE;
            err_flag <= 1'b1;
          end else if (txn_done) st <= (stat_q == 8'h00) ? S_VOUT : S_CONF;
        end
        S_VOUT: begin
          if (txn_err) begin
            st <= S_IDLE;
            err_flag <= 1'b1;
          end else if (txn_done) begin
            vout_target <= txn_rdata;
            st <= S_IDLE;
          end
        end
        S_CONF: begin
          if (txn_err) begin
            st <= S_IDLE;
            err_flag <= 1'b1;
          end else if (txn_done) begin
            fault_valid <= 1'b1;
            fault_code <= stat_q;
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (pcnt == PW'(POLL_TICKS - 1)) st <= S_STAT;
          else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign up       = vout_target > setpoint;
  assign mag      = up ? vout_target - setpoint : setpoint - vout_target;
  assign stepv    = (mag > MAXS) ? MAXS : mag;
  assign step_now = (setpoint != vout_target) && (scnt == CW'(STEP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setpoint <= SETPT_RST;
      scnt     <= CW'(STEP_TICKS - 1);
    end else if (step_now) begin
      setpoint <= up ? setpoint + stepv : setpoint - stepv;
      scnt     <= '0;
    end else if (scnt != CW'(STEP_TICKS - 1)) begin
      scnt <= scnt + 1'b1;
    end
  end
endmodule

module vrail_handshake_chk #(
  parameter int MAX_STEP   = 10,
  parameter int STEP_TICKS = 2500000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        use_alert,
  input logic        txn_req,
  input logic [1:0]  txn_op,
  input logic        txn_done,
  input logic        txn_err,
  input logic [15:0] setpoint,
  input logic [15:0] vout_target,
  input logic        fault_valid,
  input logic        err_flag
);
  logic [15:0] prev_sp, prev_tgt, dlt;
  int gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sp  <= setpoint;
      prev_tgt <= vout_target;
      gap      <= STEP_TICKS;
    end else begin
      prev_sp  <= setpoint;
      prev_tgt <= vout_target;
      if (setpoint != prev_sp) gap <= 0;
      else if (gap < STEP_TICKS) gap <= gap + 1;
    end
  end

  assign dlt = (setpoint > prev_sp) ? setpoint - prev_sp : prev_sp - setpoint;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_done && !txn_err) |=> (txn_req && $stable(txn_op)));

  p_step_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (setpoint != prev_sp) |-> (dlt <= 16'(MAX_STEP)));

  p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (setpoint != prev_sp) |-> (gap >= STEP_TICKS - 1));

  p_no_overshoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setpoint != prev_sp) |->
      ((prev_sp < prev_tgt) ? (setpoint > prev_sp && setpoint <= prev_tgt)
                            : (setpoint < prev_sp && setpoint >= prev_tgt)));

  p_fault_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  p_err_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_alert && txn_req && txn_err) |=> (!txn_req && err_flag));
endmodule

bind vrail_handshake vrail_handshake_chk #(.MAX_STEP(MAX_STEP), .STEP_TICKS(STEP_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .use_alert(use_alert), .txn_req(txn_req), .txn_op(txn_op),
  .txn_done(txn_done), .txn_err(txn_err), .setpoint(setpoint), .vout_target(vout_target),
  .fault_valid(fault_valid), .err_flag(err_flag)
);

// File: tb/vrail_handshake_tb.sv
module vrail_handshake_tb;
  localparam int MAXS = 10;
  localparam int STEP = 4;
  localparam int POLL = 6;

  logic clk = 0, rst_n = 0;
  logic use_alert = 1, alert_in = 0, dev_ready = 0;
  logic txn_req, txn_done = 0, txn_err = 0;
  logic [1:0] txn_op;
  logic [15:0] txn_rdata = 0, setpoint, vout_target;
  logic fault_valid, err_flag;
  logic [7:0] fault_code;

  always #2 clk = ~clk;

  vrail_handshake #(.MAX_STEP(MAXS), .STEP_TICKS(STEP), .POLL_TICKS(POLL), .SETPT_RST(16'd800)) u_dut (
    .clk(clk), .rst_n(rst_n), .use_alert(use_alert), .alert_in(alert_in), .dev_ready(dev_ready),
    .txn_req(txn_req), .txn_op(txn_op), .txn_done(txn_done), .txn_err(txn_err),
    .txn_rdata(txn_rdata), .setpoint(setpoint), .vout_target(vout_target),
    .fault_valid(fault_valid), .fault_code(fault_code), .err_flag(err_flag));

  int n_chk = 0, n_err = 0;
  int log_op[16];
  int log_n, nack_op, nack_left, stat_reads, hold_bad;
  logic [7:0] st_val;
  logic [15:0] vout_val;
  int fault_n, steps, sgap, low_run, gap_n;
  int gap_list[8];
  logic [7:0] fault_last;
  logic [15:0] sp_prev;
  logic req_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit log_is(input int n, input int e0, input int e1, input int e2,
                                input int e3, input int e4);
    int e[5];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3; e[4] = e4;
    if (log_n != n) return 0;
    for (int i = 0; i < n; i++) if (log_op[i] != e[i]) return 0;
    return 1;
  endfunction

  // transaction engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txn_req) begin
        automatic int op = int'(txn_op);
        if (log_n < 16) log_op[log_n] = op;
        log_n++;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          if (!txn_req || int'(txn_op) != op) hold_bad++;
        end
        if (op == nack_op && nack_left > 0) begin
          nack_left--;
          txn_err = 1;
        end else begin
          txn_done = 1;
          if (op == 1) begin
            txn_rdata = (stat_reads == 0) ? {8'h00, st_val} : 16'h0000;
            stat_reads++;
          end else if (op == 3) txn_rdata = vout_val;
          else txn_rdata = 16'h0;
        end
        @(negedge clk);
        txn_done = 0;
        txn_err = 0;
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      sp_prev = setpoint; sgap = 1000; req_prev = 0; low_run = 0;
    end else begin
      if (fault_valid) begin fault_n++; fault_last = fault_code; end
      if (txn_req && !req_prev) begin
        if (gap_n < 8) gap_list[gap_n] = low_run;
        gap_n++;
      end
      low_run = txn_req ? 0 : low_run + 1;
      req_prev = txn_req;
      if (setpoint != sp_prev) begin
        automatic int d = (setpoint > sp_prev) ? int'(setpoint - sp_prev) : int'(sp_prev - setpoint);
        steps++;
        chk(d <= MAXS, "R6 step size", d, MAXS);
        chk(sgap >= STEP - 1, "R6 step spacing", sgap, STEP - 1);
        sgap = 0;
      end else sgap++;
      sp_prev = setpoint;
    end
  end

  task automatic start_rec();
    log_n = 0; stat_reads = 0; fault_n = 0; gap_n = 0;
    nack_op = -1; nack_left = 0; steps = 0; hold_bad = 0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic run_alert(input logic [7:0] s, input logic [15:0] v);
    start_rec();
    st_val = s; vout_val = v;
    use_alert = 1;
    @(negedge clk);
    alert_in = 1;
    while (log_n < 1) @(negedge clk);
    alert_in = 0;
    settle();
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    join_none

    start_rec();
    repeat (3) @(negedge clk);
    chk(setpoint == 16'd800, "R1 setpoint reset", setpoint, 800);
    chk(vout_target == 16'd800, "R1 target reset", vout_target, 800);
    chk(!txn_req && !fault_valid && !err_flag, "R1 outputs idle", {txn_req, fault_valid, err_flag}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R8: 0384h -> 900 mV, ramp of 10 steps
    run_alert(8'h00, 16'h0384);
    chk(log_is(4, 0, 1, 2, 3, 0), "R2 op order", log_n, 4);
    chk(vout_target == 16'd900, "R8 direct format 0384h", vout_target, 900);
    chk(setpoint == 16'd900, "R7 lands on target", setpoint, 900);
    chk(steps == 10, "R7 step count", steps, 10);
    chk(hold_bad == 0, "R9 request hold", hold_bad, 0);

    // sweep of offsets
    for (int d = -25; d <= 25; d++) begin
      automatic int base = int'(setpoint);
      automatic int tgt = base + d;
      automatic int ad = (d < 0) ? -d : d;
      run_alert(8'h00, 16'(tgt));
      chk(log_is(4, 0, 1, 2, 3, 0), "R2 op order", log_n, 4);
      chk(vout_target == 16'(tgt), "R8 target", vout_target, tgt);
      chk(setpoint == 16'(tgt), "R7 final setpoint", setpoint, tgt);
      chk(steps == (ad + MAXS - 1) / MAXS, "R7 step count", steps, (ad + MAXS - 1) / MAXS);
      chk(fault_n == 0, "R2 no fault", fault_n, 0);
      chk(hold_bad == 0, "R9 request hold", hold_bad, 0);
    end

    // nonzero status
    for (int i = 0; i < 5; i++) begin
      automatic logic [7:0] s = (i == 0) ? 8'h01 : (i == 1) ? 8'h02 : (i == 2) ? 8'h40 :
                                (i == 3) ? 8'h80 : 8'hFF;
      automatic logic [15:0] t0 = vout_target;
      run_alert(s, 16'd1200);
      chk(log_is(4, 0, 1, 2, 1, 0), "R3 op order", log_n, 4);
      chk(fault_n == 1, "R3 fault pulse count", fault_n, 1);
      chk(fault_last == s, "R3 fault code", fault_last, s);
      chk(vout_target == t0, "R3 target unchanged", vout_target, t0);
    end

    // R10: dev_ready ignored in alert mode
    start_rec();
    dev_ready = 1;
    repeat (30) @(negedge clk);
    chk(log_n == 0, "R10 dev_ready ignored", log_n, 0);
    dev_ready = 0;

    // R5: refused clear in alert mode
    begin
      automatic logic [15:0] t0 = vout_target;
      start_rec();
      nack_op = 2; nack_left = 1; st_val = 0; vout_val = 16'd700;
      @(negedge clk); alert_in = 1;
      while (log_n < 1) @(negedge clk);
      alert_in = 0;
      settle();
      chk(log_is(3, 0, 1, 2, 0, 0), "R5 abort after clear", log_n, 3);
      chk(err_flag == 1'b1, "R5 err_flag set", err_flag, 1);
      chk(!txn_req, "R5 request dropped", txn_req, 0);
      chk(vout_target == t0, "R5 target unchanged", vout_target, t0);
    end
    run_alert(8'h00, 16'd780);
    chk(err_flag == 1'b0, "R5 err_flag cleared", err_flag, 1);
    chk(vout_target == 16'd780, "R8 target after recovery", vout_target, 780);

    // R10: alert ignored in polling mode
    use_alert = 0;
    start_rec();
    alert_in = 1;
    repeat (30) @(negedge clk);
    alert_in = 0;
    chk(log_n == 0, "R10 alert ignored", log_n, 0);

    // R4: polling with two refusals
    start_rec();
    nack_op = 1; nack_left = 2; st_val = 0; vout_val = 16'd850;
    dev_ready = 1;
    settle();
    chk(log_is(5, 1, 1, 1, 2, 3), "R4 poll op order", log_n, 5);
    chk(gap_list[1] == POLL, "R4 first retry gap", gap_list[1], POLL);
    chk(gap_list[2] == POLL, "R4 second retry gap", gap_list[2], POLL);
    chk(vout_target == 16'd850, "R4 target", vout_target, 850);
    chk(setpoint == 16'd850, "R7 polling ramp", setpoint, 850);
    start_rec();
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R4 level does not restart", log_n, 0);
    dev_ready = 0;
    repeat (2) @(negedge clk);

    // R5: refused voltage read in polling mode aborts
    start_rec();
    nack_op = 3; nack_left = 1; st_val = 0; vout_val = 16'd500;
    dev_ready = 1;
    settle();
    chk(log_is(3, 1, 2, 3, 0, 0), "R5 poll abort", log_n, 3);
    chk(err_flag == 1'b1, "R5 poll err_flag", err_flag, 1);
    chk(vout_target == 16'd850, "R5 poll target unchanged", vout_target, 850);
    dev_ready = 0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule